// File: doc/BRIEF.md
# Dual-Clock Byte FIFO with Offset Status Flags

This block is a first-in first-out byte buffer that sits between two clock domains. A producer stores one byte per write-clock edge while its active-low write strobe is held low. A consumer pulls one byte per read-clock edge into an output holding register while its active-low read strobe is held low. The two clocks may be one shared clock or two unrelated clocks. An active-low output enable either drives the holding register onto the output bus or leaves the bus floating.

Four active-low status flags report how many words are stored. Full and almost-full belong to the write domain, and empty and almost-empty belong to the read domain. Each partial flag sits a fixed distance of seven words from its end of the buffer. Pointers cross between the domains in Gray code through synchronizer chains. As a result a flag can release a few cycles late, but it never asserts late. An enable that arrives at a boundary is dropped without effect, so the buffer can neither overflow nor underflow.

Top module: `twinclk_fifo`

## Requirements
- R1: On a write-clock rising edge with `wenN` low and `fullN` high, the byte on `dIn` is stored. Stored bytes come out in the same order they went in.
- R2: While `fullN` is low, a write attempt stores nothing. The bytes read afterwards show no trace of it.
- R3: On a read-clock rising edge with `renN` low and `emptyN` high, the oldest stored byte moves into the holding register. While `renN` is high, the holding register keeps its value.
- R4: While `emptyN` is low, a read attempt is ignored and the holding register keeps its value.
- R5: While `rstN` is low, both pointers return to the first location, `fullN` and `afN` go high, `emptyN` and `aeN` go low, and the holding register clears to zero.
- R6: Flags follow the word count N, where D is DEPTH:
  - N=0: `emptyN`=0 and `aeN`=0.
  - 1≤N≤7: `emptyN`=1 and `aeN`=0.
  - 8≤N≤D-8: all four flags are 1.
  - D-7≤N≤D-1: `afN`=0 and `fullN`=1.
  - N=D: `fullN`=0 and `afN`=0.
- R7: Flags are registers. `fullN` and `afN` change on write-clock edges, and `emptyN` and `aeN` change on read-clock edges. `fullN` asserts on the write edge that fills the buffer. `emptyN` asserts only after a read. A newly written word releases `emptyN` no earlier than it can be read.
- R8: With `oeN` high, `qOut` is high impedance. With `oeN` low, `qOut` shows the holding register.
- R9: With unrelated clock frequencies, every accepted byte is read back once, in order, with no overflow or underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-domain clock |
| rdClk | input | 1 | Read-domain clock |
| rstN | input | 1 | Asynchronous active-low clear |
| wenN | input | 1 | Active-low write strobe |
| dIn | input | WIDTH | Byte to store |
| renN | input | 1 | Active-low read strobe |
| oeN | input | 1 | Active-low output drive enable |
| qOut | output | WIDTH | Holding register, or high impedance |
| fullN | output | 1 | Low when full (write domain) |
| afN | output | 1 | Low within seven words of full (write domain) |
| emptyN | output | 1 | Low when empty (read domain) |
| aeN | output | 1 | Low within seven words of empty (read domain) |

## Verification
The bench builds the block with DEPTH=64, WIDTH=8 and OFFSET=7. This makes every flag band boundary reachable with short bursts: 7, 8, 56, 57, 63 and 64 words. Both the full and empty boundaries are reached many times within a few thousand cycles. In tied-clock mode every band is compared against a vector table. With a faster writer against a slower reader, the small depth keeps the buffer pinned at full, which exercises the conservative flag release and the dropped writes.

// File: rtl/twinclk_fifo_pkg.sv
package twinclk_fifo_pkg;
  // strobes from the control into the datapath
  typedef struct packed {
    logic wrStb;  // accepted write this write-clock cycle
    logic rdStb;  // accepted read this read-clock cycle
  } fifoStrobe_t;
endpackage

// File: rtl/twinclk_fifo_sync.sv
module twinclk_fifo_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/twinclk_fifo_ctrl.sv
module twinclk_fifo_ctrl
  import twinclk_fifo_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int OFFSET      = 7,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          wenN,
  input  logic          renN,
  output fifoStrobe_t   strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          fullN,
  output logic          afN,
  output logic          emptyN,
  output logic          aeN
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wrBin, wrGray, wrBinNext, wrLevel;
  logic [PW-1:0] rdBin, rdGray, rdBinNext, rdLevel;
  logic [PW-1:0] wrGraySync, rdGraySync, wrBinSync, rdBinSync;

  assign strb.wrStb = !wenN && fullN;
  assign strb.rdStb = !renN && emptyN;

  // write domain: pointer plus full / almost-full
  assign wrBinNext = wrBin + PW'(strb.wrStb);
  assign wrLevel   = wrBinNext - rdBinSync;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
      fullN  <= 1'b1;
      afN    <= 1'b1;
    end else begin
      wrBin  <= wrBinNext;
      wrGray <= wrBinNext ^ (wrBinNext >> 1);
      fullN  <= (wrLevel != PW'(DEPTH));
      afN    <= (wrLevel < PW'(DEPTH - OFFSET));
    end
  end

  // read domain: pointer plus empty / almost-empty
  assign rdBinNext = rdBin + PW'(strb.rdStb);
  assign rdLevel   = wrBinSync - rdBinNext;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
      emptyN <= 1'b0;
      aeN    <= 1'b0;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= rdBinNext ^ (rdBinNext >> 1);
      emptyN <= (rdLevel != '0);
      aeN    <= (rdLevel > PW'(OFFSET));
    end
  end

  // Gray pointers cross into the opposite domain
  twinclk_fifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) uRdToWr (
    .clk(wrClk), .rstN(rstN), .din(rdGray), .dout(rdGraySync));
  twinclk_fifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) uWrToRd (
    .clk(rdClk), .rstN(rstN), .din(wrGray), .dout(wrGraySync));

  for (genvar i = 0; i < PW; i++) begin : g_gray2bin
    assign rdBinSync[i] = ^rdGraySync[PW-1:i];
    assign wrBinSync[i] = ^wrGraySync[PW-1:i];
  end

  assign wrAddr = wrBin[AW-1:0];
  assign rdAddr = rdBin[AW-1:0];
endmodule

// File: rtl/twinclk_fifo_dpath.sv
module twinclk_fifo_dpath
  import twinclk_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  fifoStrobe_t      strb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] din,
  input  logic             oeN,
  output logic [WIDTH-1:0] holdReg,
  output logic [WIDTH-1:0] qOut
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.wrStb) store[wrAddr] <= din;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)           holdReg <= '0;
    else if (strb.rdStb) holdReg <= store[rdAddr];
  end

  assign qOut = oeN ? {WIDTH{1'bz}} : holdReg;
endmodule

// File: rtl/twinclk_fifo.sv
module twinclk_fifo
  import twinclk_fifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int WIDTH  = 8,
  parameter int OFFSET = 7
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic             wenN,
  input  logic [WIDTH-1:0] dIn,
  input  logic             renN,
  input  logic             oeN,
  output logic [WIDTH-1:0] qOut,
  output logic             fullN,
  output logic             afN,
  output logic             emptyN,
  output logic             aeN
);
  localparam int AW = $clog2(DEPTH);

  fifoStrobe_t      strb;
  logic [AW-1:0]    wrAddr, rdAddr;
  logic [WIDTH-1:0] holdReg;

  twinclk_fifo_ctrl #(.DEPTH(DEPTH), .OFFSET(OFFSET), .SYNC_STAGES(2)) uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wenN(wenN), .renN(renN),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullN(fullN), .afN(afN), .emptyN(emptyN), .aeN(aeN));

  twinclk_fifo_dpath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uDpath (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .din(dIn), .oeN(oeN),
    .holdReg(holdReg), .qOut(qOut));
endmodule

// File: rtl/twinclk_fifo_checker.sv
module twinclk_fifo_checker #(
  parameter int WIDTH = 8
) (
  input logic             wrClk,
  input logic             rdClk,
  input logic             rstN,
  input logic             wenN,
  input logic             renN,
  input logic             fullN,
  input logic             afN,
  input logic             emptyN,
  input logic             aeN,
  input logic [WIDTH-1:0] holdReg
);
  assert_af_with_full_R6: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |-> !afN);

  assert_ae_with_empty_R6: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |-> !aeN);

  assert_full_after_write_R7: assert property (@(posedge wrClk) disable iff (!rstN)
    $fell(fullN) |-> $past(!wenN));

  assert_empty_after_read_R7: assert property (@(posedge rdClk) disable iff (!rstN)
    $fell(emptyN) |-> $past(!renN));

  assert_hold_when_idle_R3: assert property (@(posedge rdClk) disable iff (!rstN)
    renN |=> $stable(holdReg));
endmodule

bind twinclk_fifo twinclk_fifo_checker #(.WIDTH(WIDTH)) uChk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wenN(wenN), .renN(renN),
  .fullN(fullN), .afN(afN), .emptyN(emptyN), .aeN(aeN), .holdReg(holdReg));

// File: tb/twinclk_fifo_test.sv
`timescale 1ns/1ps
module twinclk_fifo_test;
  localparam int DEPTH = 64;
  localparam int WIDTH = 8;

  logic clk = 0, rdClk = 0, tieMode = 1;
  logic rstN = 0, wenN = 1, renN = 1, oeN = 0;
  logic [WIDTH-1:0] dIn = '0;
  wire  [WIDTH-1:0] qOut;
  logic fullN, afN, emptyN, aeN;

  twinclk_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .OFFSET(7)) uut (
    .wrClk(clk), .rdClk(rdClk), .rstN(rstN), .wenN(wenN), .dIn(dIn),
    .renN(renN), .oeN(oeN), .qOut(qOut),
    .fullN(fullN), .afN(afN), .emptyN(emptyN), .aeN(aeN));

  // 250 MHz write clock; read clock follows it or runs at 7 ns
  always #2 begin
    clk = ~clk;
    if (tieMode) rdClk = clk;
  end
  always #3.5 if (!tieMode) rdClk = ~rdClk;

  int checks = 0, fails = 0;
  logic [WIDTH-1:0] model[$];
  logic [WIDTH-1:0] lastOut = '0, nextByte = 8'h3C;
  int accW = 0, rdGot = 0, wrCap = 1 << 30;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 0; wenN = 1; renN = 1;
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);
    model.delete(); lastOut = '0; accW = 0; rdGot = 0;
  endtask

  task automatic writeWords(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (accW >= wrCap) wenN = 1;
      else begin
        wenN = 0; dIn = nextByte;
        if (fullN) begin
          if (model.size() >= DEPTH) check(0, "R9", "overflow", model.size(), DEPTH);
          model.push_back(nextByte); nextByte++; accW++;
        end
      end
    end
    @(negedge clk) wenN = 1;
  endtask

  task automatic settleRead(input bit acc, input string req);
    logic [WIDTH-1:0] exp;
    if (acc) begin
      if (model.size() == 0) check(0, "R9", "underflow", 1, 0);
      else begin
        exp = model.pop_front(); lastOut = exp; rdGot++;
        check(qOut == exp, req, "read data", qOut, exp);
      end
    end else check(qOut == lastOut, "R4", "hold at empty", qOut, lastOut);
  endtask

  task automatic readWords(input int n, input string req);
    bit acc = 0, pend = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge rdClk);
      if (pend) settleRead(acc, req);
      acc = emptyN; renN = 0; pend = 1;
    end
    @(negedge rdClk);
    if (pend) settleRead(acc, req);
    renN = 1;
  endtask

  // {isRead, count, expected {fullN, afN, aeN, emptyN}}
  localparam bit [12:0] VEC [16] = '{
    {1'b0, 8'd1,  4'b1101}, {1'b0, 8'd6,  4'b1101}, {1'b0, 8'd1,  4'b1111},
    {1'b0, 8'd48, 4'b1111}, {1'b0, 8'd1,  4'b1011}, {1'b0, 8'd6,  4'b1011},
    {1'b0, 8'd1,  4'b0011}, {1'b0, 8'd3,  4'b0011}, {1'b1, 8'd1,  4'b1011},
    {1'b1, 8'd6,  4'b1011}, {1'b1, 8'd1,  4'b1111}, {1'b1, 8'd48, 4'b1111},
    {1'b1, 8'd1,  4'b1101}, {1'b1, 8'd6,  4'b1101}, {1'b1, 8'd1,  4'b1100},
    {1'b1, 8'd2,  4'b1100}};

  initial begin
    #600000;
    check(0, "R9", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    // R5 reset state
    check({fullN, afN, aeN, emptyN} == 4'b1100, "R5", "flags after reset",
          {fullN, afN, aeN, emptyN}, 4'b1100);
    check(qOut == 0, "R5", "output after reset", qOut, 0);

    // R8 output enable
    oeN = 1; #1;
    check(qOut === {WIDTH{1'bz}}, "R8", "bus floats", qOut, 0);
    oeN = 0; #1;
    check(qOut == lastOut, "R8", "bus driven", qOut, lastOut);

    // R7 latency of flags
    @(negedge clk); wenN = 0; dIn = nextByte; model.push_back(nextByte); nextByte++;
    @(negedge clk); wenN = 1;
    check(emptyN == 0, "R7", "empty not released early", emptyN, 0);
    repeat (3) @(negedge clk);
    check(emptyN == 1, "R7", "empty released", emptyN, 1);
    writeWords(DEPTH - 1);
    check(fullN == 0, "R7", "full on filling edge", fullN, 0);
    readWords(DEPTH, "R1");

    // R5 reset in mid operation
    writeWords(5); repeat (4) @(negedge clk);
    readWords(2, "R3");
    doReset();
    check({fullN, afN, aeN, emptyN} == 4'b1100, "R5", "flags after mid reset",
          {fullN, afN, aeN, emptyN}, 4'b1100);
    check(qOut == 0, "R5", "output cleared", qOut, 0);
    writeWords(1); repeat (4) @(negedge clk);
    readWords(1, "R5");

    // R6 band table, R2 dropped writes, R4 dropped reads
    doReset();
    for (int s = 0; s < 16; s++) begin
      if (VEC[s][12]) readWords(int'(VEC[s][11:4]), "R3");
      else            writeWords(int'(VEC[s][11:4]));
      repeat (6) @(negedge clk);
      check({fullN, afN, aeN, emptyN} == VEC[s][3:0], "R6", $sformatf("band step %0d", s),
            {fullN, afN, aeN, emptyN}, VEC[s][3:0]);
      if (s == 7) check(model.size() == DEPTH, "R2", "writes dropped at full",
                        model.size(), DEPTH);
    end

    // R9 unrelated clocks
    rstN = 0; tieMode = 0;
    doReset();
    wrCap = 300;
    fork
      while (accW < 300) begin writeWords(24); repeat (3) @(negedge clk); end
      while (rdGot < 300) readWords(4, "R9");
    join
    check(rdGot == 300, "R9", "words delivered", rdGot, 300);
    check(model.size() == 0, "R9", "model drained", model.size(), 0);
    repeat (8) @(negedge rdClk);
    check(emptyN == 0, "R9", "empty at end", emptyN, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule